// File: doc/BRIEF.md
# FPU Error Interrupt Latch

This block turns the floating-point unit's error-summary status into a legacy interrupt-request line. Older software reports numeric errors through an external interrupt, and it acknowledges them by writing a byte to a fixed I/O port. The block follows the numeric-error-enable bit of the control register. When that bit is set, errors are handled natively inside the core and the request line stays low. When the bit is clear, a pending error summary raises the request line.

An acknowledge write is an 8-bit I/O write to one of two consecutive ports starting at F0h. It drops the request and sends an ignore-errors flag back to the FPU. The ignore state does not end on a later register write. It lasts until the FPU's error-summary bit falls. After that the FPU monitors errors again, and a new error raises the request again.

The I/O write strobe is a plain one-cycle qualifier. It has no back-pressure, and every strobed cycle is decoded in that cycle. Both outputs come from registers, so they change only on a rising clock edge.

Top module: `fpe_irq_latch`

## Requirements
- R1: During reset and after reset is released, `irq_req` is 0 and `fpu_ignore` is 0.
- R2: If `native_err_mode` is 1 at a rising edge, then `irq_req` is 0 after that edge, whatever the other inputs are.
- R3: If `native_err_mode` is 0, `err_summary` is 1, the block is not ignoring errors and no acknowledge write is present at a rising edge, then `irq_req` is 1 after that edge.
- R4: An acknowledge write is `io_wr_valid`=1 with `io_size`=0 (8-bit) and `io_addr` equal to 16'h00F0 or 16'h00F1. If it occurs while `err_summary` is 1, then after the next edge `fpu_ignore` is 1 and `irq_req` is 0.
- R5: While `err_summary` stays 1, `fpu_ignore` stays 1 once it is set, and `irq_req` stays 0.
- R6: If `err_summary` is 0 at a rising edge, then `fpu_ignore` is 0 and `irq_req` is 0 after that edge. A later rise of `err_summary` with `native_err_mode`=0 raises `irq_req` again.
- R7: Writes to F0h or F1h with `io_size` equal to 1 (16-bit) or 2 (32-bit) have no effect on either output.
- R8: 8-bit writes to any address other than F0h and F1h (for example EFh or F2h) have no effect on either output.
- R9: An acknowledge write made while `err_summary` is 0 leaves `fpu_ignore` at 0.
- R10: The outputs are registered. An input change between clock edges does not show on `irq_req` or `fpu_ignore` before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| native_err_mode | input | 1 | Numeric-error-enable bit from the control register (bit 5) |
| err_summary | input | 1 | Error-summary bit from the FPU status word (bit 7) |
| io_wr_valid | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O port address |
| io_size | input | 2 | Write size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| irq_req | output | 1 | Registered legacy interrupt-request line |
| fpu_ignore | output | 1 | Registered ignore-numeric-errors flag to the FPU |

## Verification
The latch is driven with four kinds of input sequence:
- A rising error summary under each setting of the mode bit. This separates native reporting from legacy reporting.
- Acknowledge writes at both matching ports. These are compared with near misses: the wrong size at a matching port, and byte writes to the neighbouring ports EFh and F2h. This shows that the decode is exact.
- A held error summary after an acknowledge. This shows that the ignore state is sticky.
- A fall and a new rise of the summary, and an acknowledge sent while no error is pending. These show that only the summary bit ends the ignore state.

Every step also samples the outputs between edges, which shows they are registered.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  typedef enum logic [1:0] {
    IO_SZ_BYTE  = 2'd0,
    IO_SZ_WORD  = 2'd1,
    IO_SZ_DWORD = 2'd2,
    IO_SZ_RSVD  = 2'd3
  } io_size_e;
endpackage

// File: rtl/fpe_ack_decode.sv
module fpe_ack_decode #(
  parameter int ADDR_W     = 16,
  parameter int PORT_BASE  = 'hF0,
  parameter int PORT_COUNT = 2
) (
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              ack_hit
);
  logic [PORT_COUNT-1:0] port_match;

  for (genvar i = 0; i < PORT_COUNT; i++) begin : g_port
    localparam logic [ADDR_W-1:0] PortAddr = ADDR_W'(PORT_BASE + i);
    assign port_match[i] = (addr == PortAddr);
  end

  assign ack_hit = wr_valid && (size == fpe_pkg::IO_SZ_BYTE) && (|port_match);
endmodule

// File: rtl/fpe_ignore_track.sv
module fpe_ignore_track (
  input  logic clk,
  input  logic rst_n,
  input  logic err_summary,
  input  logic ack_hit,
  output logic ignore_q,
  output logic ignore_next
);
  always_comb begin
    if (!err_summary)  ignore_next = 1'b0;
    else if (ack_hit)  ignore_next = 1'b1;
    else               ignore_next = ignore_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ignore_q <= 1'b0;
    else        ignore_q <= ignore_next;
  end

  assert_ack_sets_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ack_hit && err_summary) |-> ignore_q);
  assert_ignore_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ignore_q && err_summary) |-> ignore_q);
  assert_summary_low_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!err_summary) |-> !ignore_q);
endmodule

// File: rtl/fpe_req_gen.sv
module fpe_req_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic native_mode,
  input  logic err_summary,
  input  logic ignore_next,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= !native_mode && err_summary && !ignore_next;
  end

  assert_native_mode_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(native_mode) |-> !irq_q);
endmodule

// File: rtl/fpe_irq_latch.sv
module fpe_irq_latch #(
  parameter int ADDR_W     = 16,
  parameter int PORT_BASE  = 'hF0,
  parameter int PORT_COUNT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              native_err_mode,
  input  logic              err_summary,
  input  logic              io_wr_valid,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [1:0]        io_size,
  output logic              irq_req,
  output logic              fpu_ignore
);
  logic ack_hit;
  logic ignore_next;

  fpe_ack_decode #(.ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE), .PORT_COUNT(PORT_COUNT)) u_dec (
    .wr_valid(io_wr_valid), .addr(io_addr), .size(io_size), .ack_hit(ack_hit));

  fpe_ignore_track u_ign (
    .clk(clk), .rst_n(rst_n), .err_summary(err_summary), .ack_hit(ack_hit),
    .ignore_q(fpu_ignore), .ignore_next(ignore_next));

  fpe_req_gen u_req (
    .clk(clk), .rst_n(rst_n), .native_mode(native_err_mode), .err_summary(err_summary),
    .ignore_next(ignore_next), .irq_q(irq_req));

  assert_pending_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!native_err_mode && err_summary && !fpu_ignore && !ack_hit) |-> irq_req);
  assert_ack_drops_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ack_hit) |-> !irq_req);
  assert_no_req_while_ignoring_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fpu_ignore |-> !irq_req);
endmodule

// File: tb/tb_fpe_irq_latch.sv
module tb_fpe_irq_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ne = 1'b0, es = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0] size = '0;
  logic irq_req, fpu_ignore;

  int total = 0, bad = 0;
  bit done = 0;
  logic m_ign = 0, m_irq = 0;
  logic exp_irq_q[$];
  logic exp_ign_q[$];
  string exp_tag_q[$];

  always #5 clk = ~clk;

  fpe_irq_latch dut (
    .clk(clk), .rst_n(rst_n), .native_err_mode(ne), .err_summary(es),
    .io_wr_valid(wr), .io_addr(addr), .io_size(size),
    .irq_req(irq_req), .fpu_ignore(fpu_ignore));

  task automatic check(string tag, logic act_irq, logic act_ign, logic e_irq, logic e_ign);
    total++;
    if (act_irq !== e_irq || act_ign !== e_ign) begin
      bad++;
      $display("FAIL %s: irq=%b ign=%b expected irq=%b ign=%b", tag, act_irq, act_ign, e_irq, e_ign);
    end
  endtask

  // driver: applies one cycle of stimulus, predicts the post-edge outputs
  task automatic step(logic n, logic e, logic w, logic [15:0] a, logic [1:0] s, string tag);
    logic ack;
    @(negedge clk);
    ne = n; es = e; wr = w; addr = a; size = s;
    #1;
    check("R10 between edges", irq_req, fpu_ignore, m_irq, m_ign);
    ack = w && (s == 2'd0) && (a == 16'h00F0 || a == 16'h00F1);
    m_ign = e ? (m_ign | ack) : 1'b0;
    m_irq = !n && e && !m_ign;
    @(posedge clk);
    exp_irq_q.push_back(m_irq);
    exp_ign_q.push_back(m_ign);
    exp_tag_q.push_back(tag);
  endtask

  // monitor: compares each result against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_tag_q.size() > 0)
        check(exp_tag_q.pop_front(), irq_req, fpu_ignore, exp_irq_q.pop_front(), exp_ign_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R1 in reset", irq_req, fpu_ignore, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 16'h0, 2'd0, "R1 after reset");
    step(1, 1, 0, 16'h0, 2'd0, "R2 native mode quiet");
    step(1, 1, 0, 16'h0, 2'd0, "R2 native mode held");
    step(0, 1, 0, 16'h0, 2'd0, "R3 legacy raise");
    step(0, 1, 1, 16'h00F0, 2'd1, "R7 16-bit to F0");
    step(0, 1, 1, 16'h00F1, 2'd2, "R7 32-bit to F1");
    step(0, 1, 1, 16'h00EF, 2'd0, "R8 byte to EF");
    step(0, 1, 1, 16'h00F2, 2'd0, "R8 byte to F2");
    step(0, 1, 1, 16'h00F0, 2'd0, "R4 ack F0");
    step(0, 1, 0, 16'h0, 2'd0, "R5 ignore held");
    step(0, 1, 0, 16'h0, 2'd0, "R5 ignore held 2");
    step(0, 0, 0, 16'h0, 2'd0, "R6 summary low clears");
    step(0, 1, 0, 16'h0, 2'd0, "R6 rearmed raise");
    step(0, 1, 1, 16'h00F1, 2'd0, "R4 ack F1");
    step(1, 1, 0, 16'h0, 2'd0, "R5 ignore under native mode");
    step(0, 0, 1, 16'h00F0, 2'd0, "R9 ack with summary low");
    step(0, 1, 0, 16'h0, 2'd0, "R9 no ignore left");
    step(1, 1, 0, 16'h0, 2'd0, "R2 native drops request");
    step(0, 0, 0, 16'h0, 2'd0, "R6 idle");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule